// File: doc/BRIEF.md
# Banked Saved Status Register with Gated System Access

This block keeps the saved processor status for one interrupt mode. When an exception is taken into that mode, it copies the live status word into a 64-bit register in one cycle. When an exception return from that mode turns out to be illegal, it sends the saved word back to the status logic one cycle later. With the word it raises a flag if the saved mode field does not hold a legal mode value.

The same register can be read and written as a system register. Requests arrive on a valid/ready stream, and results leave on a second valid/ready stream one cycle after acceptance. A request is accepted when `acc_valid` and `acc_ready` are both high. `acc_ready` is high whenever the response slot is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value. The outcome of a request depends on the caller's exception level: the access completes, is reported undefined, or traps to level 2 with a syndrome class. A configuration input pair can pin the endianness bit to a fixed value.

Top module: `banked_psr_save`

## Requirements
- R1: After reset the stored word is zero, so a completing read returns zero apart from any endianness value pinned by configuration, and `rsp_valid` and `rest_valid` are low.
- R2: With `exc_take` high at a rising edge, the register loads `cur_state`, with bit 24 forced to 0 and bits 63:32 zero. A read from the next cycle onward returns that value.
- R3: A pulse on `ret_illegal` makes `rest_valid` high exactly one cycle later, with `rest_state` equal to the stored word as it was at the pulse.
- R4: `rest_bad_mode` is 0 when `rest_state[4:0]` is one of 5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, and 1 for every other value.
- R5: A request whose encoding is not op0=2'b11, op1=3'b100, CRn=4'b0100, CRm=4'b0011, op2=3'b011 gets status 3 (no match), read data zero, and does not change the register.
- R6: A matching request with `acc_el`=0 gets status 1 (undefined) and read data zero, and a write has no effect.
- R7: A matching request with `acc_el`=1 gets status 2 (trap) with `rsp_syndrome`=6'h18 and `rsp_target_el`=2 when `acc_trap_ctl` is 1. Otherwise it gets status 1. In both cases a write has no effect.
- R8: A matching request with `acc_el` of 2 or 3 gets status 0 (done). A read returns the word zero-extended to 64 bits. A write loads `acc_wdata[31:0]` with bit 24 cleared, and bits 63:32 are ignored.
- R9: Bit 9 (endianness) reads and restores as 1 while `cfg_le_absent` is high. Otherwise it reads and restores as 0 while `cfg_be_absent` is high. With neither set, it is stored as given.
- R10: If an exception capture and an accepted completing write fall on the same edge, the capture wins. The write still gets status 0.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `acc_ready` is low and all response fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_be_absent | input | 1 | Big-endian unsupported: pin bit 9 to 0 |
| cfg_le_absent | input | 1 | Little-endian unsupported: pin bit 9 to 1 |
| exc_take | input | 1 | Exception taken into this mode |
| cur_state | input | 32 | Live status word to capture |
| ret_illegal | input | 1 | Illegal exception return in this mode |
| rest_valid | output | 1 | Restore word valid |
| rest_state | output | 32 | Saved word driven back to status logic |
| rest_bad_mode | output | 1 | Saved mode field is not a legal mode |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_el | input | 2 | Exception level of the caller |
| acc_trap_ctl | input | 1 | Nested-virtualisation control bit 0 |
| acc_op0 | input | 2 | Encoding op0 |
| acc_op1 | input | 3 | Encoding op1 |
| acc_crn | input | 4 | Encoding CRn |
| acc_crm | input | 4 | Encoding CRm |
| acc_op2 | input | 3 | Encoding op2 |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_status | output | 2 | 0 done, 1 undefined, 2 trap, 3 no match |
| rsp_rdata | output | 64 | Read data |
| rsp_syndrome | output | 6 | Trap syndrome class |
| rsp_target_el | output | 2 | Level the trap goes to |

## Verification
The bench sweeps all 32 mode values through capture and illegal return. A legality table that is missing an entry, or has one too many, shows up as a wrong `rest_bad_mode`. It sends writes from levels 0 and 1, and with a non-matching encoding, and then reads the register back. A gate that let any of these writes through would return the new data. It fires a capture and a write on the same edge to catch inverted priority. It holds off `rsp_ready` to catch a response slot that is overwritten or lets a new request in. It toggles the endianness configuration to catch a bit 9 that is not pinned, or is pinned the wrong way.

// File: rtl/psr_save_pkg.sv
package psr_save_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 64;
  localparam int MODE_W = 5;
  localparam int J_BIT  = 24;
  localparam int E_BIT  = 9;
  localparam int EL_W   = 2;
  localparam int SYN_W  = 6;
  localparam int N_LEGAL = 7;

  typedef enum logic [1:0] {
    ACC_DONE  = 2'd0,
    ACC_UNDEF = 2'd1,
    ACC_TRAP  = 2'd2,
    ACC_MISS  = 2'd3
  } acc_status_e;

  localparam logic [MODE_W-1:0] LEGAL_MODES [N_LEGAL] = '{
    5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F
  };

  function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < N_LEGAL; k++) begin
      if (m == LEGAL_MODES[k]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic [WORD_W-1:0] shape_word(input logic [WORD_W-1:0] w,
                                                   input logic be_absent,
                                                   input logic le_absent);
    logic [WORD_W-1:0] r;
    r = w;
    r[J_BIT] = 1'b0;
    if (le_absent)      r[E_BIT] = 1'b1;
    else if (be_absent) r[E_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/psr_field_store.sv
module psr_field_store
  import psr_save_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_word,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= cap_word;
    else if (wr_en)  q <= wr_word;
  end
endmodule

// File: rtl/psr_access_gate.sv
module psr_access_gate
  import psr_save_pkg::*;
#(
  parameter logic [1:0]       ENC_OP0 = 2'b11,
  parameter logic [2:0]       ENC_OP1 = 3'b100,
  parameter logic [3:0]       ENC_CRN = 4'b0100,
  parameter logic [3:0]       ENC_CRM = 4'b0011,
  parameter logic [2:0]       ENC_OP2 = 3'b011,
  parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [EL_W-1:0]  TRAP_LEVEL = 2'd2
) (
  input  logic [EL_W-1:0]  el,
  input  logic             trap_ctl,
  input  logic [1:0]       op0,
  input  logic [2:0]       op1,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output acc_status_e      status,
  output logic [SYN_W-1:0] syndrome,
  output logic [EL_W-1:0]  target_el
);
  logic enc_hit;
  assign enc_hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
                   (crm == ENC_CRM) && (op2 == ENC_OP2);

  always_comb begin
    syndrome  = '0;
    target_el = '0;
    if (!enc_hit) begin
      status = ACC_MISS;
    end else begin
      case (el)
        2'd0: status = ACC_UNDEF;
        2'd1: begin
          if (trap_ctl) begin
            status    = ACC_TRAP;
            syndrome  = TRAP_CLASS;
            target_el = TRAP_LEVEL;
          end else begin
            status = ACC_UNDEF;
          end
        end
        default: status = ACC_DONE;
      endcase
    end
  end
endmodule

// File: rtl/psr_restore_unit.sv
module psr_restore_unit
  import psr_save_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ret_illegal,
  input  logic [W-1:0] saved_word,
  output logic         rest_valid,
  output logic [W-1:0] rest_state,
  output logic         rest_bad_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_valid    <= 1'b0;
      rest_state    <= '0;
      rest_bad_mode <= 1'b0;
    end else begin
      rest_valid <= ret_illegal;
      if (ret_illegal) begin
        rest_state    <= saved_word;
        rest_bad_mode <= !mode_is_legal(saved_word[MODE_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/banked_psr_save.sv
module banked_psr_save
  import psr_save_pkg::*;
#(
  parameter logic [SYN_W-1:0] TRAP_CLASS = 6'h18,
  parameter logic [EL_W-1:0]  TRAP_LEVEL = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_be_absent,
  input  logic              cfg_le_absent,
  input  logic              exc_take,
  input  logic [WORD_W-1:0] cur_state,
  input  logic              ret_illegal,
  output logic              rest_valid,
  output logic [WORD_W-1:0] rest_state,
  output logic              rest_bad_mode,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [EL_W-1:0]   acc_el,
  input  logic              acc_trap_ctl,
  input  logic [1:0]        acc_op0,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [EL_W-1:0]   rsp_target_el
);
  localparam int PAD_W = REG_W - WORD_W;

  logic [WORD_W-1:0] stored;
  logic [WORD_W-1:0] view;
  acc_status_e       dec_status;
  logic [SYN_W-1:0]  dec_syn;
  logic [EL_W-1:0]   dec_tel;
  logic              accept;
  logic              wr_go;

  assign view      = shape_word(stored, cfg_be_absent, cfg_le_absent);
  assign acc_ready = !rsp_valid || rsp_ready;
  assign accept    = acc_valid && acc_ready;
  assign wr_go     = accept && acc_write && (dec_status == ACC_DONE);

  psr_access_gate #(
    .TRAP_CLASS(TRAP_CLASS),
    .TRAP_LEVEL(TRAP_LEVEL)
  ) u_gate (
    .el(acc_el), .trap_ctl(acc_trap_ctl),
    .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm), .op2(acc_op2),
    .status(dec_status), .syndrome(dec_syn), .target_el(dec_tel)
  );

  psr_field_store #(.W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cap_en(exc_take),
    .cap_word(shape_word(cur_state, cfg_be_absent, cfg_le_absent)),
    .wr_en(wr_go),
    .wr_word(shape_word(acc_wdata[WORD_W-1:0], cfg_be_absent, cfg_le_absent)),
    .q(stored)
  );

  psr_restore_unit #(.W(WORD_W)) u_rest (
    .clk(clk), .rst_n(rst_n),
    .ret_illegal(ret_illegal), .saved_word(view),
    .rest_valid(rest_valid), .rest_state(rest_state), .rest_bad_mode(rest_bad_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_status    <= '0;
      rsp_rdata     <= '0;
      rsp_syndrome  <= '0;
      rsp_target_el <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_status    <= dec_status;
      rsp_syndrome  <= dec_syn;
      rsp_target_el <= dec_tel;
      if (!acc_write && dec_status == ACC_DONE) rsp_rdata <= {{PAD_W{1'b0}}, view};
      else                                      rsp_rdata <= '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/psr_save_chk.sv
module psr_save_chk
  import psr_save_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_le_absent,
  input logic              ret_illegal,
  input logic              rest_valid,
  input logic [WORD_W-1:0] rest_state,
  input logic              rest_bad_mode,
  input logic              acc_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_status,
  input logic [REG_W-1:0]  rsp_rdata,
  input logic [SYN_W-1:0]  rsp_syndrome,
  input logic [EL_W-1:0]   rsp_target_el
);
  a_r3_restore_next: assert property (@(posedge clk) disable iff (!rst_n)
    ret_illegal |=> rest_valid);

  a_r2_no_j_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rest_valid |-> !rest_state[J_BIT]);

  a_r4_mode_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rest_valid |-> (rest_bad_mode == !mode_is_legal(rest_state[MODE_W-1:0])));

  a_r7_trap_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd2) |-> (rsp_syndrome == 6'h18 && rsp_target_el == 2'd2));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[REG_W-1:WORD_W] == '0));

  a_r5_no_data_unless_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_rdata == '0));

  a_r9_le_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_valid && cfg_le_absent && $past(cfg_le_absent)) |-> rest_state[E_BIT]);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_status)));

  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !acc_ready);
endmodule

bind banked_psr_save psr_save_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_le_absent(cfg_le_absent),
  .ret_illegal(ret_illegal), .rest_valid(rest_valid), .rest_state(rest_state),
  .rest_bad_mode(rest_bad_mode), .acc_ready(acc_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
  .rsp_syndrome(rsp_syndrome), .rsp_target_el(rsp_target_el)
);

// File: tb/test_banked_psr_save.sv
`timescale 1ns/1ps
module test_banked_psr_save;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_be_absent = 1'b0, cfg_le_absent = 1'b0;
  logic exc_take = 1'b0;
  logic [31:0] cur_state = '0;
  logic ret_illegal = 1'b0;
  logic rest_valid, rest_bad_mode;
  logic [31:0] rest_state;
  logic acc_valid = 1'b0, acc_ready, acc_write = 1'b0, acc_trap_ctl = 1'b0;
  logic [1:0] acc_el = '0, acc_op0 = 2'b11;
  logic [2:0] acc_op1 = 3'b100, acc_op2 = 3'b011;
  logic [3:0] acc_crn = 4'b0100, acc_crm = 4'b0011;
  logic [63:0] acc_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [1:0] rsp_status;
  logic [63:0] rsp_rdata;
  logic [5:0] rsp_syndrome;
  logic [1:0] rsp_target_el;

  int checks = 0;
  int fails = 0;
  logic [1:0]  got_st;
  logic [63:0] got_rd;
  logic [5:0]  got_syn;
  logic [1:0]  got_tel;

  always #4 clk = ~clk;

  banked_psr_save i_banked_psr_save (.*);

  typedef struct packed {
    logic        wr;
    logic [1:0]  el;
    logic        trap;
    logic        hit;
    logic [31:0] wd;
    logic [1:0]  st;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b0, 1'b1, 32'h1234_5678, 2'd0, 32'h0},           // R8 write
    '{1'b0, 2'd3, 1'b0, 1'b1, 32'h0,         2'd0, 32'h1234_5678},   // R8 read
    '{1'b1, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd1, 32'h0},           // R6 write blocked
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0,         2'd0, 32'h1234_5678},   // R6 unchanged
    '{1'b1, 2'd1, 1'b1, 1'b1, 32'h0,         2'd2, 32'h0},           // R7 trap
    '{1'b1, 2'd1, 1'b0, 1'b1, 32'h0,         2'd1, 32'h0},           // R7 undefined
    '{1'b1, 2'd3, 1'b0, 1'b0, 32'h0,         2'd3, 32'h0},           // R5 no match
    '{1'b0, 2'd3, 1'b0, 1'b1, 32'h0,         2'd0, 32'h1234_5678},   // R5 R7 unchanged
    '{1'b0, 2'd0, 1'b0, 1'b1, 32'h0,         2'd1, 32'h0},           // R6 read blocked
    '{1'b1, 2'd3, 1'b0, 1'b1, 32'hFFFF_FFFF, 2'd0, 32'h0},           // R8 J cleared
    '{1'b0, 2'd2, 1'b0, 1'b1, 32'h0,         2'd0, 32'hFEFF_FFFF}    // R8 readback
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_acc(input logic wr, input logic [1:0] el, input logic trap,
                           input logic hit, input logic [31:0] wd);
    acc_valid    = 1'b1;
    acc_write    = wr;
    acc_el       = el;
    acc_trap_ctl = trap;
    acc_op2      = hit ? 3'b011 : 3'b000;
    acc_wdata    = {32'hDEAD_BEEF, wd};
  endtask

  task automatic access(input logic wr, input logic [1:0] el, input logic trap,
                        input logic hit, input logic [31:0] wd);
    @(negedge clk);
    drive_acc(wr, el, trap, hit, wd);
    @(negedge clk);
    acc_valid = 1'b0;
    got_st  = rsp_status;
    got_rd  = rsp_rdata;
    got_syn = rsp_syndrome;
    got_tel = rsp_target_el;
  endtask

  task automatic capture(input logic [31:0] w);
    @(negedge clk);
    exc_take  = 1'b1;
    cur_state = w;
    @(negedge clk);
    exc_take = 1'b0;
  endtask

  task automatic do_return();
    @(negedge clk);
    ret_illegal = 1'b1;
    @(negedge clk);
    ret_illegal = 1'b0;
  endtask

  function automatic logic legal_ref(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {63'b0, rsp_valid}, 64'h0);
    chk("R1 rest_valid", {63'b0, rest_valid}, 64'h0);
    chk("R1 acc_ready", {63'b0, acc_ready}, 64'h1);
    access(1'b0, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R1 read after reset", got_rd, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].el, VEC[i].trap, VEC[i].hit, VEC[i].wd);
      chk($sformatf("R5-8 vec%0d status", i), {62'b0, got_st}, {62'b0, VEC[i].st});
      chk($sformatf("R8 vec%0d rdata", i), got_rd, {32'h0, VEC[i].rd});
      if (VEC[i].st == 2'd2) begin
        chk("R7 syndrome", {58'b0, got_syn}, 64'h18);
        chk("R7 target level", {62'b0, got_tel}, 64'h2);
      end
    end

    // R2 capture clears J bit
    capture(32'hA5A5_1234);
    access(1'b0, 2'd3, 1'b0, 1'b1, 32'h0);
    chk("R2 capture readback", got_rd, 64'h0000_0000_A4A5_1234);

    // R3 restore
    do_return();
    chk("R3 rest_valid", {63'b0, rest_valid}, 64'h1);
    chk("R3 rest_state", {32'h0, rest_state}, 64'hA4A5_1234);
    @(negedge clk);
    chk("R3 rest_valid drops", {63'b0, rest_valid}, 64'h0);

    // R9 endianness pinning
    cfg_be_absent = 1'b1;
    access(1'b0, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R9 be absent read", got_rd, 64'hA4A5_1034);
    cfg_le_absent = 1'b1;
    access(1'b0, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R9 le absent read", got_rd, 64'hA4A5_1234);
    access(1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_0000);
    do_return();
    chk("R9 le absent restore", {32'h0, rest_state}, 64'h0000_0200);
    cfg_le_absent = 1'b0;
    do_return();
    chk("R9 be absent restore", {32'h0, rest_state}, 64'h0);
    cfg_be_absent = 1'b0;

    // R4 all mode values
    for (int m = 0; m < 32; m++) begin
      capture({27'h0, 5'(m)});
      do_return();
      chk($sformatf("R4 mode %0d", m), {63'b0, rest_bad_mode}, {63'b0, !legal_ref(5'(m))});
    end

    // R10 capture beats write on the same edge
    @(negedge clk);
    exc_take  = 1'b1;
    cur_state = 32'h0000_0013;
    drive_acc(1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_0010);
    @(negedge clk);
    exc_take  = 1'b0;
    acc_valid = 1'b0;
    chk("R10 write status", {62'b0, rsp_status}, 64'h0);
    access(1'b0, 2'd2, 1'b0, 1'b1, 32'h0);
    chk("R10 capture wins", got_rd, 64'h13);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive_acc(1'b0, 2'd3, 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    drive_acc(1'b1, 2'd3, 1'b0, 1'b1, 32'h0000_00FF);
    chk("R11 held valid", {63'b0, rsp_valid}, 64'h1);
    chk("R11 ready low", {63'b0, acc_ready}, 64'h0);
    @(negedge clk);
    chk("R11 data held", rsp_rdata, 64'h13);
    acc_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", {63'b0, rsp_valid}, 64'h0);
    access(1'b0, 2'd3, 1'b0, 1'b1, 32'h0);
    chk("R11 blocked write dropped", got_rd, 64'h13);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule